// File: doc/BRIEF.md
# OTG Reverse-Boost Start Sequencer

This controller decides when a battery-fed reverse-boost converter may begin switching to power an external device through a USB port, and which of two port paths it drives. It combines live comparator flags with host enable bits. The battery must be above its rising threshold and free of overvoltage, VBUS must be below its undervoltage level, and the thermistor must read inside its hot/cold window. It also applies a table, keyed by which port switch pairs were found populated at power-on, that says which path enables are needed before the converter is allowed to start.

Once every condition holds, a fixed start delay (5 ms by default, counted in clock cycles derived from the clock frequency) must elapse before the run output rises. The loss of any condition removes run and both gate drives at once and restarts the delay. This gives a clean port swap: the host clears the active port's enable, which stops switching, and then sets the other port's enable. The block also monitors the battery discharge limit. A 2-bit code selects the limit or disables it, and the code sets whether soft-start is applied. An over-limit reading drives a live status bit, a one-cycle interrupt pulse and a maskable latched flag.

Top module: `otg_start_seq`

## Requirements
- R1: `conv_run` is 0 in every cycle in which any of these is false: `otg_en`=1, `vbat_above`=1, `vbat_ovp`=0, `vbus_below_uv`=1, `ts_in_window`=1.
- R2: With `drv_disable`=1, or with `pop_port1`=`pop_port2`=0, no path enable is needed. `conv_run` rises after the start delay and both gate drives stay 0.
- R3: With only `pop_port1`=1 and `drv_disable`=0, `conv_run` stays 0 until `path_en1`=1. `path_en2` alone does not start it.
- R4: With only `pop_port2`=1 and `drv_disable`=0, `conv_run` stays 0 until `path_en2`=1.
- R5: With both populated and `drv_disable`=0, either path enable is enough to start.
- R6: `gate_port1` (and likewise `gate_port2`) is 1 exactly when `conv_run`=1, that port is populated, its path enable is 1 and `drv_disable`=0. Clearing the active enable stops run in the same cycle, and setting the other enable restarts run with the other gate.
- R7: `conv_run` first rises DELAY_CYC = CLK_KHZ*DELAY_US/1000 clock edges after all start conditions become true. Any drop of a condition restarts the count from zero.
- R8: A condition that drops while the delay is counting or while running deasserts `conv_run` and both gates in the same cycle (combinationally).
- R9: `dchg_status` equals `dchg_over` while `dchg_code` is 00 (3 A), 01 (4 A) or 10 (5 A). With code 11 the limit is off and `dchg_over` is ignored: status, pulse and flag stay 0.
- R10: `dchg_irq` is a single-cycle pulse, registered one cycle after each rising edge of the qualified over-limit condition. It is not repeated while the condition stays high.
- R11: `dchg_flag` is set on that rising edge only when `dchg_mask`=0. It holds until `flag_clr`=1, which clears it on the next edge, and a simultaneous new event wins over the clear.
- R12: `soft_start_en` = `conv_run` and (`dchg_code` != 11).
- R13: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbat_above | input | 1 | Battery above OTG rising threshold |
| vbat_ovp | input | 1 | Battery overvoltage detected |
| vbus_below_uv | input | 1 | VBUS below its undervoltage level |
| ts_in_window | input | 1 | Thermistor inside hot/cold window |
| pop_port1 | input | 1 | Port 1 switch pair populated at power-on |
| pop_port2 | input | 1 | Port 2 switch pair populated at power-on |
| drv_disable | input | 1 | Global path-driver disable |
| otg_en | input | 1 | Host OTG enable |
| path_en1 | input | 1 | Host path enable, port 1 |
| path_en2 | input | 1 | Host path enable, port 2 |
| dchg_over | input | 1 | Battery discharge current above limit |
| dchg_code | input | 2 | Discharge limit code: 00=3A, 01=4A, 10=5A, 11=off |
| dchg_mask | input | 1 | Mask for the latched flag |
| flag_clr | input | 1 | Read-clear strobe for the latched flag |
| conv_run | output | 1 | Converter switching permitted |
| gate_port1 | output | 1 | Port 1 path gate drive |
| gate_port2 | output | 1 | Port 2 path gate drive |
| soft_start_en | output | 1 | Output-current soft-start active |
| dchg_status | output | 1 | Live discharge regulation status |
| dchg_flag | output | 1 | Latched discharge flag |
| dchg_irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench first targets the start delay boundary. It samples `conv_run` one cycle before and exactly at DELAY_CYC edges, and it drops a condition halfway through the count. A design with an off-by-one or a count that resumes instead of restarting would start a cycle early or late. The population table is exercised in every configuration, including an enable for the wrong port. A design that decoded the table loosely would start on `path_en2` with only port 1 populated, or would drive a gate while `drv_disable` is set. A port swap checks that run and the gate fall in the same cycle and come back only on the other gate after a full delay. On the discharge side, holding `dchg_over` high catches a repeating interrupt, a masked event catches a flag that ignores the mask, and code 11 catches a design that still reports or soft-starts when the limit is off.

// File: rtl/otg_seq_pkg.sv
package otg_seq_pkg;

  // Discharge limit code; 11 turns the limit (and soft-start) off.
  typedef enum logic [1:0] {
    DCH_3A  = 2'b00,
    DCH_4A  = 2'b01,
    DCH_5A  = 2'b10,
    DCH_OFF = 2'b11
  } dchg_code_e;

  // Power-on population snapshot plus the global driver disable.
  typedef struct packed {
    logic drv_dis;
    logic pop2;
    logic pop1;
  } path_cfg_t;

  // True while a discharge limit is in force.
  function automatic logic dchg_limit_on(logic [1:0] code);
    return code != DCH_OFF;
  endfunction

  // Which path enables the population table demands before a start.
  function automatic logic path_permit(path_cfg_t cfg, logic en1, logic en2);
    logic ok;
    if (cfg.drv_dis) begin
      ok = 1'b1;
    end else begin
      case ({cfg.pop2, cfg.pop1})
        2'b00:   ok = 1'b1;
        2'b01:   ok = en1;
        2'b10:   ok = en2;
        default: ok = en1 | en2;
      endcase
    end
    return ok;
  endfunction

  // Start delay in clock cycles from clock in kHz and delay in microseconds.
  function automatic int unsigned delay_cycles(int unsigned clk_khz, int unsigned dly_us);
    return (clk_khz * dly_us) / 1000;
  endfunction

endpackage

// File: rtl/otg_permit.sv
module otg_permit
  import otg_seq_pkg::*;
(
  input  logic      vbat_above,
  input  logic      vbat_ovp,
  input  logic      vbus_below_uv,
  input  logic      ts_in_window,
  input  logic      otg_en,
  input  path_cfg_t cfg,
  input  logic      path_en1,
  input  logic      path_en2,
  output logic      cond_ok,
  output logic      path_ok,
  output logic      start_go
);
  logic bat_ok;

  always_comb begin
    bat_ok   = vbat_above & ~vbat_ovp;
    cond_ok  = otg_en & bat_ok & vbus_below_uv & ts_in_window;
    path_ok  = path_permit(cfg, path_en1, path_en2);
    start_go = cond_ok & path_ok;
  end
endmodule

// File: rtl/otg_delay_timer.sv
module otg_delay_timer #(
  parameter int unsigned CYC = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic done
);
  localparam int unsigned LIM = (CYC < 1) ? 1 : CYC;
  localparam int unsigned W   = $clog2(LIM + 1);
  localparam logic [W-1:0] LAST = W'(LIM);

  logic [W-1:0] cnt;
  logic         at_last;

  assign at_last = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!go) begin
      cnt <= '0;
    end else if (!at_last) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Run leaves combinationally with go (no registered lag on removal).
  assign done = go & at_last;

  // R7: the count never passes its limit
  p_cnt_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R7: a dropped go restarts the count from zero
  p_cnt_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (cnt == '0));

  // R8: no done without go
  p_done_needs_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> go);
endmodule

// File: rtl/otg_dchg_mon.sv
module otg_dchg_mon
  import otg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       over_raw,
  input  logic [1:0] code,
  input  logic       mask,
  input  logic       clr,
  output logic       status,
  output logic       flag,
  output logic       irq,
  output logic       ss_allow
);
  logic over_q;
  logic over_prev;
  logic over_rise;

  assign ss_allow  = dchg_limit_on(code);
  assign over_q    = over_raw & ss_allow;
  assign over_rise = over_q & ~over_prev;
  assign status    = over_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      over_prev <= 1'b0;
      irq       <= 1'b0;
      flag      <= 1'b0;
    end else begin
      over_prev <= over_q;
      irq       <= over_rise;
      if (over_rise && !mask) begin
        flag <= 1'b1;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

  // R10: the pulse lasts one cycle while the condition stays high
  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && over_raw && $stable(code) |-> !$past(irq));

  // R11: the flag only rises with the mask clear
  p_flag_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> !$past(mask));

  // R9: with the limit off nothing is reported
  p_off_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (code == DCH_OFF) |-> !status);
endmodule

// File: rtl/otg_start_seq.sv
module otg_start_seq
  import otg_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 125000,
  parameter int unsigned DELAY_US = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vbat_above,
  input  logic       vbat_ovp,
  input  logic       vbus_below_uv,
  input  logic       ts_in_window,
  input  logic       pop_port1,
  input  logic       pop_port2,
  input  logic       drv_disable,
  input  logic       otg_en,
  input  logic       path_en1,
  input  logic       path_en2,
  input  logic       dchg_over,
  input  logic [1:0] dchg_code,
  input  logic       dchg_mask,
  input  logic       flag_clr,
  output logic       conv_run,
  output logic       gate_port1,
  output logic       gate_port2,
  output logic       soft_start_en,
  output logic       dchg_status,
  output logic       dchg_flag,
  output logic       dchg_irq
);
  localparam int unsigned DELAY_CYC = delay_cycles(CLK_KHZ, DELAY_US);
  localparam int unsigned NPORT     = 2;

  path_cfg_t        cfg;
  logic             cond_ok;
  logic             path_ok;
  logic             start_go;
  logic             run_w;
  logic             ss_allow;
  logic [NPORT-1:0] pop_vec;
  logic [NPORT-1:0] en_vec;
  logic [NPORT-1:0] gate_vec;

  assign cfg     = '{drv_dis: drv_disable, pop2: pop_port2, pop1: pop_port1};
  assign pop_vec = {pop_port2, pop_port1};
  assign en_vec  = {path_en2, path_en1};

  otg_permit u_permit (
    .vbat_above    (vbat_above),
    .vbat_ovp      (vbat_ovp),
    .vbus_below_uv (vbus_below_uv),
    .ts_in_window  (ts_in_window),
    .otg_en        (otg_en),
    .cfg           (cfg),
    .path_en1      (path_en1),
    .path_en2      (path_en2),
    .cond_ok       (cond_ok),
    .path_ok       (path_ok),
    .start_go      (start_go)
  );

  otg_delay_timer #(.CYC(DELAY_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (start_go),
    .done  (run_w)
  );

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign gate_vec[p] = run_w & pop_vec[p] & en_vec[p] & ~drv_disable;
    end
  endgenerate

  otg_dchg_mon u_dchg (
    .clk      (clk),
    .rst_n    (rst_n),
    .over_raw (dchg_over),
    .code     (dchg_code),
    .mask     (dchg_mask),
    .clr      (flag_clr),
    .status   (dchg_status),
    .flag     (dchg_flag),
    .irq      (dchg_irq),
    .ss_allow (ss_allow)
  );

  assign conv_run      = run_w;
  assign gate_port1    = gate_vec[0];
  assign gate_port2    = gate_vec[1];
  assign soft_start_en = run_w & ss_allow;

  // R1: running implies every live condition holds
  p_run_needs_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_run |-> (otg_en && vbat_above && !vbat_ovp && vbus_below_uv && ts_in_window));

  // R3: port-1-only population needs the port 1 enable
  p_port1_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_run && pop_port1 && !pop_port2 && !drv_disable |-> path_en1);

  // R4: port-2-only population needs the port 2 enable
  p_port2_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_run && pop_port2 && !pop_port1 && !drv_disable |-> path_en2);

  // R5: both populated needs at least one enable
  p_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_run && pop_port1 && pop_port2 && !drv_disable |-> (path_en1 || path_en2));

  // R6: a gate never drives without run or with the driver disabled
  p_gate_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_port1 || gate_port2) |-> (conv_run && !drv_disable));

  // R7: run rises only after a cycle in which the start permit already held
  p_rise_after_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_run) |-> $past(start_go));

  // R12: soft-start only while running
  p_ss_needs_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_start_en |-> conv_run);
endmodule

// File: tb/sim_otg_start_seq.sv
module sim_otg_start_seq;
  localparam int unsigned CLK_KHZ  = 125000;
  localparam int unsigned DELAY_US = 1;
  localparam int          DLY      = 125;  // 125000 kHz * 1 us / 1000

  localparam int S_RUN = 0, S_G1 = 1, S_G2 = 2, S_SS = 3, S_STAT = 4, S_FLAG = 5, S_IRQ = 6;

  typedef struct {
    int    due;
    int    sig;
    bit    val;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vbat_above = 0, vbat_ovp = 0, vbus_below_uv = 0, ts_in_window = 0;
  logic pop_port1 = 0, pop_port2 = 0, drv_disable = 0;
  logic otg_en = 0, path_en1 = 0, path_en2 = 0;
  logic dchg_over = 0, dchg_mask = 0, flag_clr = 0;
  logic [1:0] dchg_code = 2'b00;
  logic conv_run, gate_port1, gate_port2, soft_start_en, dchg_status, dchg_flag, dchg_irq;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  otg_start_seq #(.CLK_KHZ(CLK_KHZ), .DELAY_US(DELAY_US)) u0 (
    .clk(clk), .rst_n(rst_n),
    .vbat_above(vbat_above), .vbat_ovp(vbat_ovp), .vbus_below_uv(vbus_below_uv),
    .ts_in_window(ts_in_window), .pop_port1(pop_port1), .pop_port2(pop_port2),
    .drv_disable(drv_disable), .otg_en(otg_en), .path_en1(path_en1), .path_en2(path_en2),
    .dchg_over(dchg_over), .dchg_code(dchg_code), .dchg_mask(dchg_mask), .flag_clr(flag_clr),
    .conv_run(conv_run), .gate_port1(gate_port1), .gate_port2(gate_port2),
    .soft_start_en(soft_start_en), .dchg_status(dchg_status), .dchg_flag(dchg_flag),
    .dchg_irq(dchg_irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit sig_val(int s);
    case (s)
      S_RUN:   return conv_run;
      S_G1:    return gate_port1;
      S_G2:    return gate_port2;
      S_SS:    return soft_start_en;
      S_STAT:  return dchg_status;
      S_FLAG:  return dchg_flag;
      default: return dchg_irq;
    endcase
  endfunction

  // Monitor: compare due items away from the active edge.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due <= cyc) begin
        n_checks++;
        if (sb[i].due < cyc || sig_val(sb[i].sig) !== sb[i].val) begin
          n_errors++;
          $display("FAIL %s: signal %0d at cycle %0d actual=%0b expected=%0b",
                   sb[i].req, sb[i].sig, cyc, sig_val(sb[i].sig), sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  // Driver side helpers
  task automatic expect_at(int dly, int s, bit v, string req);
    exp_t e;
    e.due = cyc + dly; e.sig = s; e.val = v; e.req = req;
    sb.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic all_good();
    vbat_above = 1; vbat_ovp = 0; vbus_below_uv = 1; ts_in_window = 1;
  endtask

  task automatic idle();
    otg_en = 0; path_en1 = 0; path_en2 = 0; drv_disable = 0;
    pop_port1 = 0; pop_port2 = 0;
    step(3);
  endtask

  // Expect a start DLY edges after the cycle the permit became true.
  task automatic expect_start(bit g1, bit g2, string req);
    expect_at(DLY - 1, S_RUN, 1'b0, req);
    expect_at(DLY, S_RUN, 1'b1, req);
    expect_at(DLY, S_G1, g1, req);
    expect_at(DLY, S_G2, g2, req);
    step(DLY + 2);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 20000) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    step(3);
    // R13: reset state
    expect_at(0, S_RUN, 0, "R13"); expect_at(0, S_G1, 0, "R13"); expect_at(0, S_G2, 0, "R13");
    expect_at(0, S_SS, 0, "R13");  expect_at(0, S_STAT, 0, "R13");
    expect_at(0, S_FLAG, 0, "R13"); expect_at(0, S_IRQ, 0, "R13");
    step(1);
    rst_n = 1;
    step(2);

    // R2 / R7 / R12: nothing populated, OTG enable alone starts after delay
    all_good();
    otg_en = 1;
    expect_at(DLY, S_SS, 1, "R12");
    expect_start(0, 0, "R2");

    // R8: loss of the thermistor window drops run at once
    ts_in_window = 0;
    expect_at(0, S_RUN, 0, "R8");
    expect_at(0, S_SS, 0, "R12");
    step(2);
    // R7: drop mid-count restarts the delay
    ts_in_window = 1;
    step(60);
    ts_in_window = 0;
    step(2);
    ts_in_window = 1;
    expect_start(0, 0, "R7");

    // R1: each condition alone blocks the start
    vbat_above = 0; step(DLY + 10); expect_at(0, S_RUN, 0, "R1"); step(1); vbat_above = 1; step(1);
    vbat_ovp = 1; expect_at(0, S_RUN, 0, "R1"); step(DLY + 10); expect_at(0, S_RUN, 0, "R1");
    vbat_ovp = 0; vbus_below_uv = 0; step(DLY + 10); expect_at(0, S_RUN, 0, "R1");
    vbus_below_uv = 1; otg_en = 0; step(DLY + 10); expect_at(0, S_RUN, 0, "R1");
    idle();

    // R4: only port 2 populated
    pop_port2 = 1; otg_en = 1; step(DLY + 10); expect_at(0, S_RUN, 0, "R4");
    path_en2 = 1;
    expect_start(0, 1, "R4");
    idle();

    // R3: only port 1 populated; wrong port enable does nothing
    pop_port1 = 1; otg_en = 1; path_en2 = 1;
    step(DLY + 10); expect_at(0, S_RUN, 0, "R3"); expect_at(0, S_G2, 0, "R3");
    step(1);
    path_en1 = 1;
    expect_start(1, 0, "R3");
    idle();

    // R5 / R6: both populated, port swap
    pop_port1 = 1; pop_port2 = 1; otg_en = 1; step(DLY + 10); expect_at(0, S_RUN, 0, "R5");
    step(1);
    path_en1 = 1;
    expect_start(1, 0, "R5");
    path_en1 = 0;
    expect_at(0, S_RUN, 0, "R6"); expect_at(0, S_G1, 0, "R6");
    step(4);
    path_en2 = 1;
    expect_start(0, 1, "R6");
    idle();

    // R2 / R6: driver disable overrides population and suppresses gates
    pop_port1 = 1; pop_port2 = 1; drv_disable = 1; otg_en = 1; path_en1 = 1;
    expect_start(0, 0, "R2");
    expect_at(0, S_G1, 0, "R6");
    step(1);

    // R9 / R10 / R11: discharge monitor, mask clear
    dchg_code = 2'b01;
    dchg_over = 1;
    expect_at(0, S_STAT, 1, "R9");
    expect_at(1, S_IRQ, 1, "R10"); expect_at(1, S_FLAG, 1, "R11");
    expect_at(2, S_IRQ, 0, "R10"); expect_at(5, S_IRQ, 0, "R10");
    expect_at(5, S_FLAG, 1, "R11");
    step(6);
    flag_clr = 1; step(1); flag_clr = 0;
    expect_at(0, S_FLAG, 0, "R11");
    dchg_over = 0;
    expect_at(0, S_STAT, 0, "R9");
    step(2);

    // R11: masked event pulses but leaves the flag clear
    dchg_mask = 1; dchg_over = 1;
    expect_at(1, S_IRQ, 1, "R10"); expect_at(1, S_FLAG, 0, "R11"); expect_at(3, S_FLAG, 0, "R11");
    step(4);
    dchg_over = 0; dchg_mask = 0; step(2);

    // R9 / R12: code 11 ignores over-limit and removes soft-start
    dchg_code = 2'b11;
    expect_at(0, S_SS, 0, "R12"); expect_at(0, S_RUN, 1, "R12");
    dchg_over = 1;
    expect_at(0, S_STAT, 0, "R9"); expect_at(1, S_IRQ, 0, "R9"); expect_at(2, S_FLAG, 0, "R9");
    step(4);
    dchg_code = 2'b10;
    expect_at(0, S_SS, 1, "R12"); expect_at(0, S_STAT, 1, "R9"); expect_at(1, S_IRQ, 1, "R10");
    step(4);

    step(4);
    if (sb.size() != 0) begin
      n_checks++; n_errors++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule